// File: doc/BRIEF.md
# High-Speed Clock Source Switch Controller

This block decides which of two high-speed oscillators feeds the system clock. One is a quick-starting RC oscillator that is not very accurate. The other is an accurate crystal oscillator that takes a long time to start. Software writes a source-select level and power-down requests. The controller watches a stable flag from each oscillator and changes the glitch-free clock-mux select only when the newly chosen oscillator is stable. The registered select output also serves as the status bit that software polls to see that a switch has finished.

The block also runs a one-shot RC calibration each time the crystal becomes the source. While that calibration, or an external low-power RC calibration, is outstanding, it locks out three requests: a switch back to RC, powering down the RC oscillator, and entry into a low-power mode. It handles low-power entry and wake-up as well. On wake it re-arms calibration when the crystal is selected. Waking from the deeper levels discards the stored RC trim.

The analog oscillators, the calibration engine and the clock-gating cell are not modelled. They appear only as handshake inputs and outputs.

Top module: `hs_clk_switch`

## Requirements
- R1: After reset, sys_src=1 (RC source), pd_state=1, rc_en=1, xo_en=0, and switch_busy, cal_start, rc_cal_ok, lpm_ack and lp_active are all 0.
- R2: sel_req=0 requests the crystal and sel_req=1 requests RC. An accepted change raises switch_busy on the next cycle. sys_src takes the new value one cycle after the first clock edge where switch_busy=1 and the target's stable flag is 1, and switch_busy falls on that same cycle. sys_src never changes otherwise.
- R3: While switch_busy=1, changes on sel_req are held. The level present once switch_busy has fallen is taken as a fresh request.
- R4: While lp_active=1, both xo_en and rc_en are 0. Otherwise, with pd_state=0 both are 1, and with pd_state=1 only the enable of the source named by sys_src is 1. pd_state is 0 whenever switch_busy=1.
- R5: A pd_wr with pd_wdata=1 sets pd_state only when no switch is pending and the stable flag of the current source is 1 (subject also to R8). The earliest effect is two cycles after the write. A pd_wr with pd_wdata=0 clears pd_state on the next cycle.
- R6: Accepting a source-select change clears pd_state, and also drops any waiting power-down request.
- R7: Each switch to the crystal arms exactly one RC calibration. It is a single-cycle cal_start, issued while sys_src=0 once xo_stable=1. cal_done ends the calibration and sets rc_cal_ok=1. No further cal_start occurs until the source is switched away and back, or until an R11 wake.
- R8: While a calibration is armed or running, or while lp_cal_busy=1, three requests are held: a switch to RC, a power-down while the crystal is selected, and a low-power request, which is dropped.
- R9: An lpm_req with lpm_lvl in 1..3 is granted when no switch is pending and nothing in R8 blocks it. A grant gives a one-cycle lpm_ack together with lp_active=1. An lpm_lvl of 0 is ignored.
- R10: rc_cal_ok is kept when the RC oscillator is powered down (rc_en=0).
- R11: A wake pulse while lp_active=1 clears lp_active. If the crystal is selected, one RC calibration follows once xo_stable=1. A wake from level 2 or 3 clears rc_cal_ok. A wake from level 1 keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_req | input | 1 | Requested source: 0 crystal, 1 RC |
| pd_wr | input | 1 | Power-down control write strobe |
| pd_wdata | input | 1 | Power-down value written |
| xo_stable | input | 1 | Crystal oscillator stable |
| rc_stable | input | 1 | RC oscillator stable |
| cal_done | input | 1 | RC calibration finished pulse |
| lp_cal_busy | input | 1 | Low-power RC calibration running |
| lpm_req | input | 1 | Low-power entry request pulse |
| lpm_lvl | input | 2 | Requested low-power level, 1..3 |
| wake | input | 1 | Return-to-active pulse |
| sys_src | output | 1 | Clock-mux select and source status: 0 crystal, 1 RC |
| switch_busy | output | 1 | A source switch is pending |
| pd_state | output | 1 | Power-down control in effect |
| xo_en | output | 1 | Crystal oscillator enable |
| rc_en | output | 1 | RC oscillator enable |
| cal_start | output | 1 | RC calibration start pulse |
| rc_cal_ok | output | 1 | RC running on a calibrated trim |
| lpm_ack | output | 1 | Low-power entry granted pulse |
| lp_active | output | 1 | In a low-power mode |

## Verification
The bench models the crystal as becoming stable 20 cycles after its enable rises and the RC oscillator after 3 cycles. Its calibration stub answers 25 cycles after cal_start. Because the crystal start is long, a select change can be made while a switch is still pending. Because the calibration window is wide, switch, power-down and low-power requests all land while a calibration is outstanding. The short RC start lets switches back to RC complete fast enough for a few thousand random cycles to cover many full switch, power-down and sleep round trips.

// File: rtl/hs_clk_switch.sv
module hs_clk_switch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_req,
  input  logic       pd_wr,
  input  logic       pd_wdata,
  input  logic       xo_stable,
  input  logic       rc_stable,
  input  logic       cal_done,
  input  logic       lp_cal_busy,
  input  logic       lpm_req,
  input  logic [1:0] lpm_lvl,
  input  logic       wake,
  output logic       sys_src,
  output logic       switch_busy,
  output logic       pd_state,
  output logic       xo_en,
  output logic       rc_en,
  output logic       cal_start,
  output logic       rc_cal_ok,
  output logic       lpm_ack,
  output logic       lp_active
);

  logic       tgt, pend, pd, pd_hold, cal_arm, cal_busy, lp_act;
  logic [1:0] lp_lvl;

  wire blocked  = cal_busy | cal_arm | lp_cal_busy;
  wire cur_ok   = sys_src ? rc_stable : xo_stable;
  wire tgt_ok   = tgt ? rc_stable : xo_stable;
  wire accept   = !lp_act && !pend && (sel_req != tgt) && !(sel_req && blocked);
  wire swap     = pend && tgt_ok;
  wire pd_ok    = pd_hold && !pend && cur_ok && !(!sys_src && blocked);
  wire cal_go   = cal_arm && !cal_busy && !pend && !sys_src && xo_stable && !lp_act;
  wire grant    = lpm_req && !lp_act && !pend && !blocked && (lpm_lvl != 2'd0);
  wire wake_hit = wake && lp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_src   <= 1'b1;
      tgt       <= 1'b1;
      pend      <= 1'b0;
      pd        <= 1'b1;
      pd_hold   <= 1'b0;
      cal_arm   <= 1'b0;
      cal_busy  <= 1'b0;
      cal_start <= 1'b0;
      rc_cal_ok <= 1'b0;
      lp_act    <= 1'b0;
      lp_lvl    <= 2'd0;
      lpm_ack   <= 1'b0;
    end else begin
      cal_start <= cal_go;
      lpm_ack   <= grant;

      if (accept) begin
        tgt  <= sel_req;
        pend <= 1'b1;
      end else if (swap) begin
        sys_src <= tgt;
        pend    <= 1'b0;
      end

      if (accept) begin
        pd      <= 1'b0;
        pd_hold <= 1'b0;
      end else if (pd_wr && !pd_wdata) begin
        pd      <= 1'b0;
        pd_hold <= 1'b0;
      end else if (pd_wr) begin
        pd_hold <= 1'b1;
      end else if (pd_ok) begin
        pd      <= 1'b1;
        pd_hold <= 1'b0;
      end

      if (accept && !sel_req) begin
        cal_arm <= 1'b1;
      end else if (wake_hit && !sys_src) begin
        cal_arm <= 1'b1;
      end else if (cal_go) begin
        cal_arm <= 1'b0;
      end

      if (cal_go) begin
        cal_busy <= 1'b1;
      end else if (cal_busy && cal_done) begin
        cal_busy <= 1'b0;
      end

      if (cal_busy && cal_done) begin
        rc_cal_ok <= 1'b1;
      end else if (wake_hit && lp_lvl >= 2'd2) begin
        rc_cal_ok <= 1'b0;
      end

      if (grant) begin
        lp_act <= 1'b1;
        lp_lvl <= lpm_lvl;
      end else if (wake_hit) begin
        lp_act <= 1'b0;
      end
    end
  end

  assign switch_busy = pend;
  assign pd_state    = pd;
  assign lp_active   = lp_act;
  assign xo_en       = !lp_act && (!pd || !sys_src || !tgt);
  assign rc_en       = !lp_act && (!pd || sys_src || tgt);

  AST_SWAP_RC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_src) |-> $past(rc_stable)); // R2
  AST_SWAP_XO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_src) |-> $past(xo_stable)); // R2
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend) |-> (tgt == $past(tgt))); // R3
  AST_PD_ONE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state && !lp_active) |-> (xo_en != rc_en)); // R4
  AST_PD_SET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_state) |-> $past(sys_src ? rc_stable : xo_stable)); // R5
  AST_TOGGLE_CLEARS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(switch_busy) |-> !pd_state); // R6
  AST_CAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start); // R7
  AST_RC_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt) |-> $past(!cal_busy && !cal_arm && !lp_cal_busy)); // R8
  AST_LPM_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    lpm_ack |-> $past(!cal_busy && !lp_cal_busy && lpm_lvl != 2'd0)); // R9

endmodule

// File: tb/tb_hs_clk_switch.sv
`timescale 1ns/1ps
module tb_hs_clk_switch;
  localparam int XO_LAT  = 20;
  localparam int RC_LAT  = 3;
  localparam int CAL_LAT = 25;
  localparam int WD      = 150000;

  logic clk, rst_n;
  logic sel_req, pd_wr, pd_wdata, xo_stable, rc_stable, cal_done, lp_cal_busy;
  logic lpm_req, wake;
  logic [1:0] lpm_lvl;
  logic sys_src, switch_busy, pd_state, xo_en, rc_en, cal_start, rc_cal_ok, lpm_ack, lp_active;

  hs_clk_switch dut (
    .clk(clk), .rst_n(rst_n), .sel_req(sel_req), .pd_wr(pd_wr), .pd_wdata(pd_wdata),
    .xo_stable(xo_stable), .rc_stable(rc_stable), .cal_done(cal_done),
    .lp_cal_busy(lp_cal_busy), .lpm_req(lpm_req), .lpm_lvl(lpm_lvl), .wake(wake),
    .sys_src(sys_src), .switch_busy(switch_busy), .pd_state(pd_state), .xo_en(xo_en),
    .rc_en(rc_en), .cal_start(cal_start), .rc_cal_ok(rc_cal_ok), .lpm_ack(lpm_ack),
    .lp_active(lp_active)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_cal = 0, cycles = 0;
  int xo_cnt = 0, rc_cnt = 0, cal_cnt = 0;
  logic cal_run = 1'b0, armed = 1'b0;
  logic p_src, p_pd, p_busy, p_cs, p_lp, p_xs, p_rs, p_calrun, p_lpc, p_lreq;
  logic [1:0] p_lvl;

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  function automatic int exp_xo(logic lp, logic pd, logic src);
    return int'(!lp && (!pd || !src));
  endfunction
  function automatic int exp_rc(logic lp, logic pd, logic src);
    return int'(!lp && (!pd || src));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD) begin
      n_bad++;
      $display("FAIL watchdog R1..all got=%0d exp<=%0d", cycles, WD);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && armed) begin
      if (sys_src != p_src) begin
        chk("R2 swap needs target stable", sys_src ? p_rs : p_xs, 1);
        chk("R2 swap only while busy", p_busy, 1);
      end
      if (switch_busy && !p_busy) begin
        chk("R6 toggle clears pd", pd_state, 0);
        if (!sys_src) chk("R8 no RC switch while calibrating", p_calrun | p_lpc, 0);
      end
      chk("R4 xo_en", xo_en, exp_xo(lp_active, pd_state, sys_src));
      chk("R4 rc_en", rc_en, exp_rc(lp_active, pd_state, sys_src));
      if (switch_busy) chk("R4 pd low while busy", pd_state, 0);
      if (pd_state && !p_pd) begin
        chk("R5 pd set needs stable source", p_src ? p_rs : p_xs, 1);
        chk("R5 pd set not while pending", p_busy, 0);
      end
      if (cal_start) begin
        chk("R7 cal_start single cycle", p_cs, 0);
        chk("R7 cal after crystal stable", p_xs, 1);
        chk("R7 cal with crystal selected", sys_src, 0);
      end
      if (lpm_ack) begin
        chk("R8 lpm blocked by calibration", p_calrun | p_lpc, 0);
        chk("R9 ack with request", p_lreq, 1);
        chk("R9 ack needs nonzero level", int'(p_lvl != 2'd0), 1);
        chk("R9 ack sets lp_active", lp_active, 1);
      end
      if (lp_active && !p_lp) chk("R9 lp entry only by ack", lpm_ack, 1);
    end
    if (!rst_n) begin
      cal_done = 1'b0; cal_run = 1'b0; cal_cnt = 0;
    end else if (cal_done) begin
      cal_done = 1'b0; cal_run = 1'b0;
    end else if (cal_start) begin
      n_cal++; cal_run = 1'b1; cal_cnt = CAL_LAT;
    end else if (cal_run && cal_cnt > 0) begin
      cal_cnt--;
      if (cal_cnt == 0) cal_done = 1'b1;
    end
    if (!xo_en) begin xo_cnt = 0; xo_stable = 1'b0; end
    else begin if (xo_cnt < XO_LAT) xo_cnt++; xo_stable = (xo_cnt >= XO_LAT); end
    if (!rc_en) begin rc_cnt = 0; rc_stable = 1'b0; end
    else begin if (rc_cnt < RC_LAT) rc_cnt++; rc_stable = (rc_cnt >= RC_LAT); end
    p_src = sys_src; p_pd = pd_state; p_busy = switch_busy; p_cs = cal_start;
    p_lp = lp_active; p_xs = xo_stable; p_rs = rc_stable; p_calrun = cal_run;
    p_lpc = lp_cal_busy; p_lreq = lpm_req; p_lvl = lpm_lvl;
    if (rst_n) armed = 1'b1;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic pd_write(logic v);
    pd_wr = 1'b1; pd_wdata = v; cyc(1); pd_wr = 1'b0;
  endtask
  task automatic lpm(logic [1:0] v);
    lpm_req = 1'b1; lpm_lvl = v; cyc(1); lpm_req = 1'b0;
  endtask
  task automatic wake_pulse();
    wake = 1'b1; cyc(1); wake = 1'b0;
  endtask
  task automatic wait_src(logic v, string tag);
    for (int i = 0; i < 400; i++) begin
      if (sys_src == v) break;
      cyc(1);
    end
    chk(tag, sys_src, v);
  endtask
  task automatic wait_cal(int k);
    for (int i = 0; i < 500; i++) begin
      if (n_cal >= k && !cal_run && !cal_done) break;
      cyc(1);
    end
    chk("R7 calibration completed", int'(n_cal >= k), 1);
  endtask

  initial begin
    int k, seed;
    rst_n = 1'b0; sel_req = 1'b1; pd_wr = 1'b0; pd_wdata = 1'b0;
    xo_stable = 1'b0; rc_stable = 1'b0; cal_done = 1'b0; lp_cal_busy = 1'b0;
    lpm_req = 1'b0; lpm_lvl = 2'd0; wake = 1'b0;
    seed = $urandom(32'h1f2e3d4c);
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 sys_src", sys_src, 1);
    chk("R1 pd_state", pd_state, 1);
    chk("R1 rc_en", rc_en, 1);
    chk("R1 xo_en", xo_en, 0);
    chk("R1 busy", switch_busy, 0);
    chk("R1 rc_cal_ok", rc_cal_ok, 0);
    chk("R1 lp_active", lp_active, 0);
    chk("R1 lpm_ack", lpm_ack, 0);
    cyc(5);

    sel_req = 1'b0;
    cyc(3);
    chk("R2 source unchanged before stable", sys_src, 1);
    chk("R2 busy during switch", switch_busy, 1);
    chk("R6 toggle cleared pd", pd_state, 0);
    chk("R4 both run with pd low", xo_en & rc_en, 1);
    wait_src(1'b0, "R2 crystal selected");
    for (int i = 0; i < 50 && !cal_run; i++) cyc(1);
    cyc(2);
    sel_req = 1'b1;
    cyc(5);
    chk("R8 RC switch held during cal", sys_src, 0);
    chk("R8 no busy during cal", switch_busy, 0);
    lpm(2'd3);
    cyc(3);
    chk("R8 lpm rejected during cal", lp_active, 0);
    sel_req = 1'b0;
    wait_cal(1);
    cyc(40);
    chk("R7 single calibration", n_cal, 1);
    chk("R7 rc_cal_ok after done", rc_cal_ok, 1);
    sel_req = 1'b1;
    wait_src(1'b1, "R2 back to RC");

    pd_write(1'b1); cyc(3);
    chk("R5 pd set on stable source", pd_state, 1);
    chk("R4 crystal off with pd", xo_en, 0);
    pd_write(1'b0);
    chk("R5 pd cleared by write", pd_state, 0);
    chk("R4 crystal back on", xo_en, 1);
    pd_write(1'b1); cyc(3);
    chk("R5 pd set again", pd_state, 1);
    sel_req = 1'b0;
    cyc(2);
    chk("R6 toggle clears pd", pd_state, 0);
    chk("R2 busy", switch_busy, 1);
    sel_req = 1'b1;
    cyc(5);
    chk("R3 held request no effect", sys_src, 1);
    chk("R3 still pending", switch_busy, 1);
    k = n_cal;
    wait_src(1'b0, "R3 pending switch finished");
    wait_src(1'b1, "R3 held request taken later");
    chk("R7 one cal per switch", n_cal, k + 1);

    pd_write(1'b1); cyc(3);
    sel_req = 1'b0;
    cyc(1);
    pd_write(1'b1);
    cyc(5);
    chk("R5 pd waits for pending switch", pd_state, 0);
    wait_src(1'b0, "R2 crystal again");
    cyc(2);
    chk("R8 RC power-down held during cal", pd_state, 0);
    wait_cal(k + 2);
    cyc(4);
    chk("R5 pd applied after cal", pd_state, 1);
    chk("R10 rc off", rc_en, 0);
    chk("R10 trim kept while off", rc_cal_ok, 1);

    lp_cal_busy = 1'b1;
    lpm(2'd2); cyc(3);
    chk("R8 lpm rejected by lp cal", lp_active, 0);
    lp_cal_busy = 1'b0;
    lpm(2'd0); cyc(3);
    chk("R9 level 0 ignored", lp_active, 0);
    lpm(2'd2);
    chk("R9 ack pulse", lpm_ack, 1);
    cyc(1);
    chk("R9 ack one cycle", lpm_ack, 0);
    chk("R9 lp active", lp_active, 1);
    chk("R4 oscillators off in lp", xo_en | rc_en, 0);
    k = n_cal;
    wake_pulse();
    cyc(1);
    chk("R11 lp cleared", lp_active, 0);
    chk("R11 level 2 drops trim", rc_cal_ok, 0);
    cyc(5);
    chk("R11 cal waits for crystal", n_cal, k);
    wait_cal(k + 1);
    cyc(2);
    chk("R11 one wake calibration", n_cal, k + 1);
    chk("R11 trim restored", rc_cal_ok, 1);

    sel_req = 1'b1;
    wait_src(1'b1, "R2 RC for level-1 sleep");
    lpm(2'd1); cyc(3);
    chk("R9 level 1 granted", lp_active, 1);
    k = n_cal;
    wake_pulse();
    cyc(30);
    chk("R11 lp cleared", lp_active, 0);
    chk("R11 level 1 keeps trim", rc_cal_ok, 1);
    chk("R11 no cal on RC wake", n_cal, k);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) sel_req = ~sel_req;
      pd_wr = ($urandom_range(29) == 0);
      pd_wdata = $urandom_range(1);
      lpm_req = ($urandom_range(59) == 0);
      lpm_lvl = 2'($urandom_range(3));
      wake = lp_active && ($urandom_range(14) == 0);
      if ($urandom_range(49) == 0) lp_cal_busy = ~lp_cal_busy;
      cyc(1);
    end
    pd_wr = 1'b0; lpm_req = 1'b0; wake = 1'b0;
    cyc(5);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule